// File: doc/BRIEF.md
# Kernel Control Register Slave

This block sits between a host on an AXI4-Lite bus and the compute core of an accelerator kernel. The host loads argument words, then sets a start request bit. The block holds a start request toward the core until the core acknowledges it. It then records completion in a sticky done flag, which the host can poll. Two interrupt sources, the start acknowledge and completion, are recorded in a status register. Each source can be masked on its own, and a single global enable gates the active-high interrupt line.

The argument area begins at byte offset 0x10. The four words below it hold the control and interrupt registers. The first `N_SCALAR` argument words are 32-bit scalars. They are followed by `N_PTR` 64-bit buffer addresses, each made of two 32-bit words with the low word first. All arguments are driven to the core as flat parallel buses. The active-low reset input is registered once inside the block before it is used.

Top module: `kctl_regslave`

## Requirements
- R1: While `rst_n` is low on a clock edge, and from the edge after that, every register is zero: all reads return 0, and `core_start` and `irq` are low.
- R2: At offset 0x00, a write that has bit 0 set and `s_wstrb[0]` high raises `core_start`, and bit 0 reads back as 1. `core_start` stays high until an edge where `core_start_ack` is high, then it clears. Writing 0 to bit 0 does not clear it.
- R3: Bit 1 of offset 0x00 is set by a `core_done` pulse and stays set. A read of 0x00 returns it as 1 and clears it, so the next read returns 0.
- R4: Bit 0 of offset 0x04 is the global interrupt enable. Bits 1:0 of offset 0x08 are the per-source enables. Bits 1:0 of offset 0x0C are the status bits: bit 0 is set by `core_done`, and bit 1 is set when `core_start_ack` meets a pending start. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R5: `irq` is high exactly when the global enable is set and some status bit has its per-source enable set.
- R6: Argument word k sits at byte offset 0x10+4k. Words k < `N_SCALAR` drive `scalar_args[32k+:32]`. Pointer j takes its low word at 0x10+4(`N_SCALAR`+2j) and its high word at the next offset, and drives `ptr_args[64j+:64]`.
- R7: Bit i of `s_wstrb` updates only byte i (bits 8i+7:8i) of the addressed argument word.
- R8: Reads of offsets beyond the last argument word return 0, and writes there change nothing. Every write and read response is OKAY (2'b00).
- R9: The write address and write data may be offered in either order or in the same cycle. The block handles one write at a time, and it holds `s_awready` and `s_wready` low while a write response is pending.
- R10: `s_bvalid` stays high until `s_bready` is high. `s_rvalid` stays high with stable `s_rdata` until `s_rready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 8 | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Byte enables of the write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Host takes write response |
| s_araddr | input | 8 | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Host takes read data |
| core_start | output | 1 | Start request to the core |
| core_start_ack | input | 1 | Core has taken the start request |
| core_done | input | 1 | One-cycle completion pulse from the core |
| scalar_args | output | 64 | Scalar argument words, word 0 lowest |
| ptr_args | output | 64 | Buffer address arguments, pointer 0 lowest |
| irq | output | 1 | Active-high interrupt |

## Verification
The bench tries all 32 combinations of global enable, the two per-source enables and the pending sources, and compares `irq` after each one. A design that inverted a mask or ignored the global enable would drive a wrong `irq` in some of these combinations. It applies all sixteen byte-strobe patterns to one argument word. It also clears status bits one at a time, which catches a write-to-clear that wipes the whole register or a write of 0 that clears bits. It checks that writing 0 does not abort a pending start, and that reading the done flag clears it only after returning 1. It offers the write address and data in every order, with response stalls, which exposes a channel that drops a beat or lets a response change while it is pending.

// File: rtl/kctl_pkg.sv
package kctl_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int WADR_W = ADDR_W - 2;
    localparam int N_IRQ  = 2;

    localparam logic [WADR_W-1:0] W_CTRL = 6'd0;
    localparam logic [WADR_W-1:0] W_GIE  = 6'd1;
    localparam logic [WADR_W-1:0] W_IER  = 6'd2;
    localparam logic [WADR_W-1:0] W_ISR  = 6'd3;
    localparam logic [WADR_W-1:0] W_ARG0 = 6'd4;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_GIE,
        SEL_IER,
        SEL_ISR,
        SEL_ARG,
        SEL_NONE
    } sel_e;

    typedef struct packed {
        logic [WADR_W-1:0] word;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } wr_req_t;

    function automatic sel_e decode(input logic [WADR_W-1:0] w, input int nwords);
        sel_e s;
        if (w == W_CTRL)      s = SEL_CTRL;
        else if (w == W_GIE)  s = SEL_GIE;
        else if (w == W_IER)  s = SEL_IER;
        else if (w == W_ISR)  s = SEL_ISR;
        else if (int'(w) < int'(W_ARG0) + nwords) s = SEL_ARG;
        else                  s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] cur,
                                                      input logic [DATA_W-1:0] nxt,
                                                      input logic [STRB_W-1:0] strb);
        logic [DATA_W-1:0] r;
        r = cur;
        for (int b = 0; b < STRB_W; b++)
            if (strb[b]) r[8*b +: 8] = nxt[8*b +: 8];
        return r;
    endfunction

endpackage

// File: rtl/kctl_rst_pipe.sv
module kctl_rst_pipe (
    input  logic clk,
    input  logic rst_n,
    output logic rst
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= ~rst_n;

    assign rst = rst_q;
endmodule

// File: rtl/kctl_wr_chan.sv
module kctl_wr_chan import kctl_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_en,
    output wr_req_t           wr_req
);
    logic aw_got, w_got;

    assign awready = ~aw_got & ~bvalid;
    assign wready  = ~w_got & ~bvalid;
    assign wr_en   = aw_got & w_got & ~bvalid;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_got <= 1'b0;
            w_got  <= 1'b0;
            bvalid <= 1'b0;
            wr_req <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_got      <= 1'b1;
                wr_req.word <= awaddr[ADDR_W-1:2];
            end
            if (wvalid && wready) begin
                w_got       <= 1'b1;
                wr_req.data <= wdata;
                wr_req.strb <= wstrb;
            end
            if (wr_en) begin
                aw_got <= 1'b0;
                w_got  <= 1'b0;
                bvalid <= 1'b1;
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/kctl_regbank.sv
module kctl_regbank import kctl_pkg::*; #(
    parameter int N_SCALAR = 2,
    parameter int N_PTR    = 1,
    localparam int NW      = N_SCALAR + 2 * N_PTR
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  wr_req_t                  wr_req,
    input  logic                     rd_en,
    input  logic [WADR_W-1:0]        rd_word,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     start_o,
    input  logic                     start_ack,
    input  logic                     done_in,
    output logic [NW*DATA_W-1:0]     args_flat,
    output logic                     irq
);
    logic             start_q, done_q, gie_q;
    logic [N_IRQ-1:0] ier_q, isr_q, isr_set, isr_clr;
    sel_e             wsel, rsel;

    assign wsel = decode(wr_req.word, NW);
    assign rsel = decode(rd_word, NW);

    for (genvar k = 0; k < NW; k++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)
                word_q <= '0;
            else if (wr_en && wsel == SEL_ARG && int'(wr_req.word - W_ARG0) == k)
                word_q <= merge_bytes(word_q, wr_req.data, wr_req.strb);
        end
        assign args_flat[k*DATA_W +: DATA_W] = word_q;
    end

    assign isr_set = {start_q & start_ack, done_in};
    assign isr_clr = (wr_en && wsel == SEL_ISR && wr_req.strb[0]) ? wr_req.data[N_IRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            gie_q   <= 1'b0;
            ier_q   <= '0;
            isr_q   <= '0;
        end else begin
            if (wr_en && wsel == SEL_CTRL && wr_req.strb[0] && wr_req.data[0])
                start_q <= 1'b1;
            else if (start_q && start_ack)
                start_q <= 1'b0;

            if (done_in)
                done_q <= 1'b1;
            else if (rd_en && rsel == SEL_CTRL)
                done_q <= 1'b0;

            if (wr_en && wsel == SEL_GIE && wr_req.strb[0])
                gie_q <= wr_req.data[0];
            if (wr_en && wsel == SEL_IER && wr_req.strb[0])
                ier_q <= wr_req.data[N_IRQ-1:0];

            isr_q <= (isr_q & ~isr_clr) | isr_set;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            SEL_CTRL: rd_data[1:0]       = {done_q, start_q};
            SEL_GIE:  rd_data[0]         = gie_q;
            SEL_IER:  rd_data[N_IRQ-1:0] = ier_q;
            SEL_ISR:  rd_data[N_IRQ-1:0] = isr_q;
            SEL_ARG: begin
                for (int k = 0; k < NW; k++)
                    if (int'(rd_word - W_ARG0) == k) rd_data = args_flat[k*DATA_W +: DATA_W];
            end
            default:  rd_data = '0;
        endcase
    end

    assign start_o = start_q;
    assign irq     = gie_q & |(ier_q & isr_q);
endmodule

// File: rtl/kctl_regslave.sv
module kctl_regslave import kctl_pkg::*; #(
    parameter int N_SCALAR = 2,
    parameter int N_PTR    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           s_awaddr,
    input  logic                        s_awvalid,
    output logic                        s_awready,
    input  logic [DATA_W-1:0]           s_wdata,
    input  logic [STRB_W-1:0]           s_wstrb,
    input  logic                        s_wvalid,
    output logic                        s_wready,
    output logic [1:0]                  s_bresp,
    output logic                        s_bvalid,
    input  logic                        s_bready,
    input  logic [ADDR_W-1:0]           s_araddr,
    input  logic                        s_arvalid,
    output logic                        s_arready,
    output logic [DATA_W-1:0]           s_rdata,
    output logic [1:0]                  s_rresp,
    output logic                        s_rvalid,
    input  logic                        s_rready,
    output logic                        core_start,
    input  logic                        core_start_ack,
    input  logic                        core_done,
    output logic [N_SCALAR*DATA_W-1:0]  scalar_args,
    output logic [N_PTR*2*DATA_W-1:0]   ptr_args,
    output logic                        irq
);
    localparam int NW = N_SCALAR + 2 * N_PTR;

    logic                 rst, wr_en, rd_en;
    wr_req_t              wr_req;
    logic [DATA_W-1:0]    rd_word_data;
    logic [NW*DATA_W-1:0] args_flat;

    kctl_rst_pipe u_rst (.clk(clk), .rst_n(rst_n), .rst(rst));

    kctl_wr_chan u_wr (
        .clk(clk), .rst(rst),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bvalid(s_bvalid), .bready(s_bready),
        .wr_en(wr_en), .wr_req(wr_req)
    );

    assign s_arready = ~s_rvalid;
    assign rd_en     = s_arvalid & s_arready;

    kctl_regbank #(.N_SCALAR(N_SCALAR), .N_PTR(N_PTR)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_req(wr_req),
        .rd_en(rd_en), .rd_word(s_araddr[ADDR_W-1:2]), .rd_data(rd_word_data),
        .start_o(core_start), .start_ack(core_start_ack), .done_in(core_done),
        .args_flat(args_flat), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s_rvalid <= 1'b0;
            s_rdata  <= '0;
        end else if (rd_en) begin
            s_rvalid <= 1'b1;
            s_rdata  <= rd_word_data;
        end else if (s_rvalid && s_rready) begin
            s_rvalid <= 1'b0;
        end
    end

    assign s_bresp     = 2'b00;
    assign s_rresp     = 2'b00;
    assign scalar_args = args_flat[N_SCALAR*DATA_W-1:0];
    assign ptr_args    = args_flat[NW*DATA_W-1:N_SCALAR*DATA_W];
endmodule

// File: rtl/kctl_chk.sv
module kctl_chk import kctl_pkg::*; (
    input logic              clk,
    input logic              rst_n,
    input logic              awready,
    input logic              wready,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp,
    input logic              core_start,
    input logic              core_start_ack
);
    // R10
    bresp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));

    // R8
    resp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid || rvalid) |-> (bresp == 2'b00 && rresp == 2'b00));

    // R9
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (!awready && !wready));

    // R2
    start_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_start) |-> $past(core_start_ack));
endmodule

bind kctl_regslave kctl_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .awready(s_awready), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .core_start(core_start), .core_start_ack(core_start_ack)
);

// File: tb/test_kctl_regslave.sv
module test_kctl_regslave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic        core_start, core_start_ack = 0, core_done = 0, irq;
    logic [63:0] scalar_args, ptr_args;

    int nvec = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    kctl_regslave i_kctl_regslave (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .core_start(core_start), .core_start_ack(core_start_ack), .core_done(core_done),
        .scalar_args(scalar_args), .ptr_args(ptr_args), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order, input int stall);
        bit aw_left = 1, w_left = 1, aw_fire, w_fire;
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s;
        awvalid = (order != 1);
        wvalid  = (order != 0);
        while (aw_left || w_left) begin
            aw_fire = awvalid && awready;
            w_fire  = wvalid && wready;
            @(negedge clk);
            if (aw_fire) begin awvalid = 0; aw_left = 0; end
            if (w_fire)  begin wvalid = 0;  w_left = 0;  end
            if (!aw_left && w_left && !wvalid) wvalid = 1;
            if (!w_left && aw_left && !awvalid) awvalid = 1;
        end
        while (!bvalid) @(negedge clk);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk("R10 bvalid held", {63'b0, bvalid}, 64'd1);
        end
        chk("R8 bresp", {62'b0, bresp}, 64'd0);
        bready = 1;
        @(negedge clk);
        bready = 0;
    endtask

    task automatic axi_rd(input logic [7:0] a, input int stall, output logic [31:0] d);
        logic [31:0] first;
        @(negedge clk);
        araddr = a; arvalid = 1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        first = rdata;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk("R10 rdata held", {31'b0, rvalid, rdata}, {31'b0, 1'b1, first});
        end
        chk("R8 rresp", {62'b0, rresp}, 64'd0);
        d = rdata;
        rready = 1;
        @(negedge clk);
        rready = 0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); core_start_ack = 1;
        @(negedge clk); core_start_ack = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); core_done = 1;
        @(negedge clk); core_done = 0;
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'h9E37_79B9 * (k + 3) ^ (32'h0101_0101 << k);
    endfunction

    function automatic logic [31:0] bytemask(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] words [4];
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk("R1 core_start", {63'b0, core_start}, 64'd0);
        chk("R1 irq", {63'b0, irq}, 64'd0);
        for (int a = 0; a < 32; a += 4) begin
            axi_rd(8'(a), 0, d);
            chk("R1 read zero", {32'b0, d}, 64'd0);
        end

        // R6 / R9: argument words, all write orders
        for (int k = 0; k < 4; k++) begin
            words[k] = pat(k);
            axi_wr(8'(16 + 4*k), words[k], 4'hF, k % 3, k);
        end
        for (int k = 0; k < 4; k++) begin
            axi_rd(8'(16 + 4*k), k, d);
            chk("R6 arg readback", {32'b0, d}, {32'b0, words[k]});
        end
        chk("R6 scalar bus", scalar_args, {words[1], words[0]});
        chk("R6 pointer bus", ptr_args, {words[3], words[2]});

        // R7: every strobe pattern
        for (int s = 0; s < 16; s++) begin
            axi_wr(8'h10, 32'h0, 4'hF, s % 3, 0);
            axi_wr(8'h10, 32'hDEAD_BEEF, 4'(s), (s + 1) % 3, 0);
            axi_rd(8'h10, 0, d);
            chk("R7 strobe merge", {32'b0, d}, {32'b0, 32'hDEAD_BEEF & bytemask(4'(s))});
        end
        axi_wr(8'h10, words[0], 4'hF, 2, 0);

        // R8: unmapped writes ignored, reads zero
        for (int a = 32; a < 64; a += 4) axi_wr(8'(a), 32'hFFFF_FFFF, 4'hF, 2, 0);
        chk("R8 scalars untouched", scalar_args, {words[1], words[0]});
        chk("R8 pointers untouched", ptr_args, {words[3], words[2]});
        for (int a = 32; a < 256; a += 4) begin
            axi_rd(8'(a), 0, d);
            chk("R8 unmapped read", {32'b0, d}, 64'd0);
        end

        // R2: start hold, no abort, cleared by ack
        axi_wr(8'h00, 32'h1, 4'h1, 0, 0);
        chk("R2 start raised", {63'b0, core_start}, 64'd1);
        axi_rd(8'h00, 0, d);
        chk("R2 start readback", {32'b0, d}, 64'd1);
        repeat (5) @(negedge clk);
        axi_wr(8'h00, 32'h0, 4'hF, 1, 0);
        chk("R2 write 0 no abort", {63'b0, core_start}, 64'd1);
        pulse_ack();
        chk("R2 start cleared by ack", {63'b0, core_start}, 64'd0);
        // R4: ack source recorded
        axi_rd(8'h0C, 0, d);
        chk("R4 status ack bit", {32'b0, d}, 64'd2);
        axi_wr(8'h0C, 32'h2, 4'h1, 2, 0);
        axi_rd(8'h0C, 0, d);
        chk("R4 status cleared", {32'b0, d}, 64'd0);

        // R3: sticky done cleared by read
        pulse_done();
        repeat (10) @(negedge clk);
        axi_rd(8'h00, 0, d);
        chk("R3 done set", {32'b0, d}, 64'd2);
        axi_rd(8'h00, 0, d);
        chk("R3 done cleared by read", {32'b0, d}, 64'd0);

        // R4: write 0 no effect, write 1 clears one bit only
        axi_wr(8'h00, 32'h1, 4'h1, 2, 0);
        pulse_ack();
        axi_wr(8'h0C, 32'h0, 4'hF, 0, 0);
        axi_rd(8'h0C, 0, d);
        chk("R4 write 0 keeps status", {32'b0, d}, 64'd3);
        axi_wr(8'h0C, 32'h1, 4'h1, 1, 0);
        axi_rd(8'h0C, 0, d);
        chk("R4 clear bit 0 only", {32'b0, d}, 64'd2);
        axi_wr(8'h0C, 32'h3, 4'h1, 2, 0);
        axi_rd(8'h00, 0, d);

        // R5: sweep global enable, source enables and pending sources
        for (int g = 0; g < 2; g++)
            for (int e = 0; e < 4; e++)
                for (int src = 0; src < 4; src++) begin
                    axi_wr(8'h04, 32'(g), 4'h1, src % 3, 0);
                    axi_wr(8'h08, 32'(e), 4'h1, e % 3, 0);
                    axi_rd(8'h04, 0, d);
                    chk("R4 global enable readback", {32'b0, d}, 64'(g));
                    axi_rd(8'h08, 0, d);
                    chk("R4 source enable readback", {32'b0, d}, 64'(e));
                    if (src[1]) begin
                        axi_wr(8'h00, 32'h1, 4'h1, 0, 0);
                        pulse_ack();
                    end
                    if (src[0]) pulse_done();
                    @(negedge clk);
                    chk("R5 irq", {63'b0, irq}, {63'b0, (g == 1) && ((e & src) != 0)});
                    axi_rd(8'h0C, 0, d);
                    chk("R4 status sources", {32'b0, d}, 64'(src));
                    axi_wr(8'h0C, 32'h3, 4'h1, 1, 0);
                    axi_rd(8'h00, 0, d);
                    chk("R5 irq after clear", {63'b0, irq}, 64'd0);
                end

        // R1: reset clears loaded state
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R1 args after reset", scalar_args | ptr_args, 64'd0);
        axi_rd(8'h08, 0, d);
        chk("R1 enable after reset", {32'b0, d}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule